// File: doc/BRIEF.md
# Locked Translation Entry Controller

This block holds the pinned part of a translation buffer: eight fully associative entries that the ordinary invalidate-all command does not clear. It also holds a 32-bit control word with two fields. A steering bit decides where page-walk fills go. A 3-bit slot pointer chooses which pinned slot the next fill overwrites. The fill port is driven by a page-table walker. When the steering bit is set, a fill is written into the pinned slot named by the pointer, and the pointer then moves forward by one. When the bit is clear, the fill is passed on, one cycle later, as a request to the set-associative array, which sits outside this block.

A lookup port compares a virtual page against every pinned entry in the same cycle and returns the stored physical page. There are two invalidate commands, and both are also passed on to the set-associative array. The whole-buffer command leaves every pinned entry untouched. The single-page command clears every pinned entry whose virtual page matches.

Top module: `tlb_lock_ctrl`

## Requirements
- R1: After synchronous reset, every pinned entry is invalid, no lookup hits, and the control word reads 0 (pointer 0, steering bit 0).
- R2: The control word has the slot pointer in bits 28:26 and the steering bit in bit 0. All other bits are ignored on write and read back as 0. A write is visible on `ctl_rdata` in the cycle after the write edge.
- R3: With the steering bit at 1, a fill is written into the pinned slot named by the pointer. After the fill edge, a lookup of that virtual page hits and returns the filled physical page.
- R4: Each fill into a pinned slot advances the pointer by one, and the pointer wraps from 7 to 0.
- R5: With the steering bit at 0, a fill is presented on `sa_fill_*` one cycle later with the same virtual and physical pages. The pinned entries and the pointer stay unchanged.
- R6: A whole-buffer invalidate leaves every pinned entry valid and is presented on `sa_inv_all` one cycle later.
- R7: A single-page invalidate clears every valid pinned entry whose virtual page matches. It is presented on `sa_inv_one` with its page one cycle later.
- R8: A lookup is combinational. When several valid pinned entries match, the entry with the lowest index supplies `lk_ppage`.
- R9: When a control write and a fill occur in the same cycle, the fill uses the newly written steering bit and pointer. The pointer then advances from the written value.
- R10: When a fill and a matching single-page invalidate occur in the same cycle, the newly filled slot ends valid. Other matching slots are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word write data |
| ctl_rdata | output | 32 | Current control word |
| walk_valid | input | 1 | Page-walk fill strobe |
| walk_vpage | input | 20 | Fill virtual page |
| walk_ppage | input | 20 | Fill physical page |
| lk_vpage | input | 20 | Lookup virtual page |
| lk_hit | output | 1 | A valid pinned entry matches the lookup |
| lk_ppage | output | 20 | Physical page of the lowest-index matching entry |
| inv_all | input | 1 | Whole-buffer invalidate |
| inv_one | input | 1 | Single-page invalidate |
| inv_vpage | input | 20 | Page for the single-page invalidate |
| sa_fill_valid | output | 1 | Fill forwarded to the set-associative array |
| sa_fill_vpage | output | 20 | Forwarded fill virtual page |
| sa_fill_ppage | output | 20 | Forwarded fill physical page |
| sa_inv_all | output | 1 | Forwarded whole-buffer invalidate |
| sa_inv_one | output | 1 | Forwarded single-page invalidate |
| sa_inv_vpage | output | 20 | Forwarded single-page invalidate page |

## Verification
A corrupted slot pointer shows up in `ctl_rdata` on the very next cycle. It also shows up later, when a lookup of a recently filled page hits in the wrong slot or returns a page that a neighbouring fill has overwritten. A wrong valid bit shows up on the first lookup of that page. It appears as a hit that survived a single-page invalidate, as a pinned entry lost to a whole-buffer invalidate, or as a missing hit after a steered fill. The bench keeps an independent model of all eight slots and compares the control word, the forwarded requests and one lookup after every cycle. A divergence is therefore reported within the cycle in which it first becomes visible at the ports.

// File: rtl/tlb_lock_pkg.sv
package tlb_lock_pkg;
  localparam int CTRL_W   = 32;
  localparam int PTR_LSB  = 26;
  localparam int STEER_BIT = 0;
endpackage

// File: rtl/tlb_lock_ctrlreg.sv
module tlb_lock_ctrlreg
  import tlb_lock_pkg::*;
#(
  parameter int N_LOCK = 8,
  parameter int PTR_W  = $clog2(N_LOCK)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              fill_valid,
  output logic [CTRL_W-1:0] rd_data,
  output logic              lock_we,
  output logic [PTR_W-1:0]  lock_idx,
  output logic              sa_req
);
  localparam logic [PTR_W-1:0] PTR_ONE = 1;
  localparam logic [CTRL_W-1:0] FIELD_MASK =
    (((CTRL_W'(1) << PTR_W) - CTRL_W'(1)) << PTR_LSB) | (CTRL_W'(1) << STEER_BIT);

  logic [PTR_W-1:0] ptr_q;
  logic             steer_q;
  logic [PTR_W-1:0] eff_ptr;
  logic             eff_steer;
  logic             unused_rsvd;

  assign unused_rsvd = ^(wr_data & ~FIELD_MASK);

  // Control write is applied ahead of a fill in the same cycle
  always_comb begin
    eff_ptr   = wr_en ? wr_data[PTR_LSB +: PTR_W] : ptr_q;
    eff_steer = wr_en ? wr_data[STEER_BIT]        : steer_q;
    lock_we   = fill_valid & eff_steer;
    sa_req    = fill_valid & ~eff_steer;
    lock_idx  = eff_ptr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q   <= '0;
      steer_q <= 1'b0;
    end else begin
      steer_q <= eff_steer;
      ptr_q   <= lock_we ? eff_ptr + PTR_ONE : eff_ptr;
    end
  end

  always_comb begin
    rd_data = '0;
    rd_data[PTR_LSB +: PTR_W] = ptr_q;
    rd_data[STEER_BIT]        = steer_q;
  end

  assert_ptr_advance_R4: assert property (@(posedge clk) disable iff (rst)
    (lock_we && !wr_en) |=> ptr_q == $past(ptr_q) + PTR_ONE);

  assert_ptr_hold_on_forward_R5: assert property (@(posedge clk) disable iff (rst)
    (sa_req && !wr_en) |=> $stable(ptr_q));

  assert_write_before_fill_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && fill_valid && wr_data[STEER_BIT]) |=>
      ptr_q == $past(wr_data[PTR_LSB +: PTR_W]) + PTR_ONE);
endmodule

// File: rtl/tlb_lock_array.sv
module tlb_lock_array #(
  parameter int N_LOCK = 8,
  parameter int PTR_W  = $clog2(N_LOCK),
  parameter int VA_W   = 20,
  parameter int PA_W   = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [PTR_W-1:0] widx,
  input  logic [VA_W-1:0]  wvpage,
  input  logic [PA_W-1:0]  wppage,
  input  logic             inv_one,
  input  logic [VA_W-1:0]  inv_vpage,
  input  logic [VA_W-1:0]  lk_vpage,
  output logic             lk_hit,
  output logic [PA_W-1:0]  lk_ppage
);
  logic [N_LOCK-1:0] valid_q;
  logic [VA_W-1:0]   vtag_q [N_LOCK];
  logic [PA_W-1:0]   ppn_q  [N_LOCK];
  logic [N_LOCK-1:0] lk_match;
  logic [N_LOCK-1:0] inv_match;

  // Page storage: single indexed write port, no reset
  always_ff @(posedge clk) begin
    if (we) begin
      vtag_q[widx] <= wvpage;
      ppn_q[widx]  <= wppage;
    end
  end

  for (genvar g = 0; g < N_LOCK; g++) begin : g_cmp
    assign lk_match[g]  = valid_q[g] && (vtag_q[g] == lk_vpage);
    assign inv_match[g] = valid_q[g] && (vtag_q[g] == inv_vpage);

    assert_single_inv_clears_R7: assert property (@(posedge clk) disable iff (rst)
      (inv_one && inv_match[g] && !(we && widx == PTR_W'(g))) |=> !valid_q[g]);
  end

  // Fill wins over a same-cycle invalidate of the same slot
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
    end else begin
      for (int i = 0; i < N_LOCK; i++) begin
        if (we && widx == PTR_W'(i))
          valid_q[i] <= 1'b1;
        else if (inv_one && inv_match[i])
          valid_q[i] <= 1'b0;
      end
    end
  end

  // Lowest index has priority
  always_comb begin
    lk_hit   = 1'b0;
    lk_ppage = '0;
    for (int i = N_LOCK - 1; i >= 0; i--) begin
      if (lk_match[i]) begin
        lk_hit   = 1'b1;
        lk_ppage = ppn_q[i];
      end
    end
  end

  assert_entries_kept_R6: assert property (@(posedge clk) disable iff (rst)
    (!we && !inv_one) |=> $stable(valid_q));

  assert_fill_beats_inv_R10: assert property (@(posedge clk) disable iff (rst)
    (we && inv_one) |=> valid_q[$past(widx)]);

  assert_fill_sets_valid_R3: assert property (@(posedge clk) disable iff (rst)
    we |=> $countones(valid_q) >= 1);
endmodule

// File: rtl/tlb_lock_route.sv
module tlb_lock_route #(
  parameter int VA_W = 20,
  parameter int PA_W = 20
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fill_req,
  input  logic [VA_W-1:0] fill_vpage,
  input  logic [PA_W-1:0] fill_ppage,
  input  logic            inv_all,
  input  logic            inv_one,
  input  logic [VA_W-1:0] inv_vpage,
  output logic            sa_fill_valid,
  output logic [VA_W-1:0] sa_fill_vpage,
  output logic [PA_W-1:0] sa_fill_ppage,
  output logic            sa_inv_all,
  output logic            sa_inv_one,
  output logic [VA_W-1:0] sa_inv_vpage
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sa_fill_valid <= 1'b0;
      sa_inv_all    <= 1'b0;
      sa_inv_one    <= 1'b0;
    end else begin
      sa_fill_valid <= fill_req;
      sa_inv_all    <= inv_all;
      sa_inv_one    <= inv_one;
    end
  end

  always_ff @(posedge clk) begin
    sa_fill_vpage <= fill_vpage;
    sa_fill_ppage <= fill_ppage;
    sa_inv_vpage  <= inv_vpage;
  end

  assert_forward_fill_R5: assert property (@(posedge clk) disable iff (rst)
    fill_req |=> sa_fill_valid && sa_fill_vpage == $past(fill_vpage));

  assert_forward_inv_all_R6: assert property (@(posedge clk) disable iff (rst)
    inv_all |=> sa_inv_all);

  assert_forward_inv_one_R7: assert property (@(posedge clk) disable iff (rst)
    inv_one |=> sa_inv_one && sa_inv_vpage == $past(inv_vpage));
endmodule

// File: rtl/tlb_lock_ctrl.sv
module tlb_lock_ctrl
  import tlb_lock_pkg::*;
#(
  parameter int N_LOCK = 8,
  parameter int VA_W   = 20,
  parameter int PA_W   = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_we,
  input  logic [CTRL_W-1:0] ctl_wdata,
  output logic [CTRL_W-1:0] ctl_rdata,
  input  logic              walk_valid,
  input  logic [VA_W-1:0]   walk_vpage,
  input  logic [PA_W-1:0]   walk_ppage,
  input  logic [VA_W-1:0]   lk_vpage,
  output logic              lk_hit,
  output logic [PA_W-1:0]   lk_ppage,
  input  logic              inv_all,
  input  logic              inv_one,
  input  logic [VA_W-1:0]   inv_vpage,
  output logic              sa_fill_valid,
  output logic [VA_W-1:0]   sa_fill_vpage,
  output logic [PA_W-1:0]   sa_fill_ppage,
  output logic              sa_inv_all,
  output logic              sa_inv_one,
  output logic [VA_W-1:0]   sa_inv_vpage
);
  localparam int PTR_W = $clog2(N_LOCK);

  logic             lock_we;
  logic [PTR_W-1:0] lock_idx;
  logic             sa_req;

  tlb_lock_ctrlreg #(.N_LOCK(N_LOCK), .PTR_W(PTR_W)) u_ctrlreg (
    .clk(clk), .rst(rst),
    .wr_en(ctl_we), .wr_data(ctl_wdata), .fill_valid(walk_valid),
    .rd_data(ctl_rdata), .lock_we(lock_we), .lock_idx(lock_idx), .sa_req(sa_req)
  );

  tlb_lock_array #(.N_LOCK(N_LOCK), .PTR_W(PTR_W), .VA_W(VA_W), .PA_W(PA_W)) u_array (
    .clk(clk), .rst(rst),
    .we(lock_we), .widx(lock_idx), .wvpage(walk_vpage), .wppage(walk_ppage),
    .inv_one(inv_one), .inv_vpage(inv_vpage),
    .lk_vpage(lk_vpage), .lk_hit(lk_hit), .lk_ppage(lk_ppage)
  );

  tlb_lock_route #(.VA_W(VA_W), .PA_W(PA_W)) u_route (
    .clk(clk), .rst(rst),
    .fill_req(sa_req), .fill_vpage(walk_vpage), .fill_ppage(walk_ppage),
    .inv_all(inv_all), .inv_one(inv_one), .inv_vpage(inv_vpage),
    .sa_fill_valid(sa_fill_valid), .sa_fill_vpage(sa_fill_vpage),
    .sa_fill_ppage(sa_fill_ppage), .sa_inv_all(sa_inv_all),
    .sa_inv_one(sa_inv_one), .sa_inv_vpage(sa_inv_vpage)
  );
endmodule

// File: tb/tlb_lock_ctrl_bench.sv
module tlb_lock_ctrl_bench;
  localparam int VA_W = 20;
  localparam int PA_W = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ctl_we = 1'b0;
  logic [31:0] ctl_wdata = '0;
  logic [31:0] ctl_rdata;
  logic walk_valid = 1'b0;
  logic [VA_W-1:0] walk_vpage = '0;
  logic [PA_W-1:0] walk_ppage = '0;
  logic [VA_W-1:0] lk_vpage = '0;
  logic lk_hit;
  logic [PA_W-1:0] lk_ppage;
  logic inv_all = 1'b0, inv_one = 1'b0;
  logic [VA_W-1:0] inv_vpage = '0;
  logic sa_fill_valid, sa_inv_all, sa_inv_one;
  logic [VA_W-1:0] sa_fill_vpage, sa_inv_vpage;
  logic [PA_W-1:0] sa_fill_ppage;

  always #2 clk = ~clk;

  tlb_lock_ctrl u_tlb_lock_ctrl (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .walk_valid(walk_valid), .walk_vpage(walk_vpage), .walk_ppage(walk_ppage),
    .lk_vpage(lk_vpage), .lk_hit(lk_hit), .lk_ppage(lk_ppage),
    .inv_all(inv_all), .inv_one(inv_one), .inv_vpage(inv_vpage),
    .sa_fill_valid(sa_fill_valid), .sa_fill_vpage(sa_fill_vpage), .sa_fill_ppage(sa_fill_ppage),
    .sa_inv_all(sa_inv_all), .sa_inv_one(sa_inv_one), .sa_inv_vpage(sa_inv_vpage)
  );

  // Reference model
  bit              m_val [8];
  logic [VA_W-1:0] m_vt  [8];
  logic [PA_W-1:0] m_pp  [8];
  logic [2:0]      m_ptr = '0;
  logic            m_steer = 1'b0;
  logic            e_sfv, e_sia, e_sio;
  logic [VA_W-1:0] e_sfvp, e_sivp;
  logic [PA_W-1:0] e_sfpp;

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word();
    return {3'b000, m_ptr, 25'd0, m_steer};
  endfunction

  // One clock with the given inputs; model updated; registered outputs checked
  task automatic cyc(input logic wr, input logic [31:0] wd, input logic fv,
                     input logic [VA_W-1:0] fvp, input logic [PA_W-1:0] fpp,
                     input logic ia, input logic io, input logic [VA_W-1:0] ivp);
    logic ep;
    logic [2:0] ev;
    ctl_we = wr; ctl_wdata = wd; walk_valid = fv; walk_vpage = fvp; walk_ppage = fpp;
    inv_all = ia; inv_one = io; inv_vpage = ivp;
    ep = wr ? wd[0] : m_steer;
    ev = wr ? wd[28:26] : m_ptr;
    e_sfv = fv && !ep; e_sfvp = fvp; e_sfpp = fpp;
    e_sia = ia; e_sio = io; e_sivp = ivp;
    if (io)
      for (int i = 0; i < 8; i++)
        if (m_val[i] && m_vt[i] == ivp) m_val[i] = 1'b0;
    if (fv && ep) begin
      m_val[ev] = 1'b1; m_vt[ev] = fvp; m_pp[ev] = fpp;
      ev = ev + 3'd1;
    end
    m_ptr = ev; m_steer = ep;
    @(posedge clk); #1;
    ctl_we = 1'b0; walk_valid = 1'b0; inv_all = 1'b0; inv_one = 1'b0;
    chk("R2/R4 control word", ctl_rdata, exp_word());
    chk("R5 sa_fill_valid", {31'd0, sa_fill_valid}, {31'd0, e_sfv});
    if (e_sfv) begin
      chk("R5 sa_fill_vpage", {12'd0, sa_fill_vpage}, {12'd0, e_sfvp});
      chk("R5 sa_fill_ppage", {12'd0, sa_fill_ppage}, {12'd0, e_sfpp});
    end
    chk("R6 sa_inv_all", {31'd0, sa_inv_all}, {31'd0, e_sia});
    chk("R7 sa_inv_one", {31'd0, sa_inv_one}, {31'd0, e_sio});
    if (e_sio) chk("R7 sa_inv_vpage", {12'd0, sa_inv_vpage}, {12'd0, e_sivp});
  endtask

  task automatic look(input string tag, input logic [VA_W-1:0] vp);
    logic h;
    logic [PA_W-1:0] p;
    lk_vpage = vp;
    #1;
    h = 1'b0; p = '0;
    for (int i = 7; i >= 0; i--)
      if (m_val[i] && m_vt[i] == vp) begin h = 1'b1; p = m_pp[i]; end
    chk({tag, " hit"}, {31'd0, lk_hit}, {31'd0, h});
    if (h) chk({tag, " ppage"}, {12'd0, lk_ppage}, {12'd0, p});
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 8; i++) begin m_val[i] = 1'b0; m_vt[i] = '0; m_pp[i] = '0; end
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R1 reset state
    chk("R1 reset control word", ctl_rdata, 32'h0);
    look("R1 reset lookup", 20'h0);
    look("R1 reset lookup", 20'h11);

    // R2 reserved bits ignored, fields placed
    cyc(1, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, 0);
    chk("R2 all-ones write", ctl_rdata, 32'h1C00_0001);
    cyc(1, 32'hE3FF_FFFE, 0, 0, 0, 0, 0, 0);
    chk("R2 reserved-only write", ctl_rdata, 32'h0);

    // R3 steered fill into slot 5
    cyc(1, 32'h1400_0001, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 1, 20'h11, 20'hABCDE, 0, 0, 0);
    look("R3 steered fill", 20'h11);
    chk("R4 pointer 5->6", ctl_rdata, 32'h1800_0001);

    // R4 wrap
    cyc(1, 32'h1C00_0001, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 1, 20'h12, 20'h00042, 0, 0, 0);
    chk("R4 pointer wrap 7->0", ctl_rdata, 32'h0000_0001);
    look("R4 slot 7 filled", 20'h12);

    // R5 forwarded fill, no change
    cyc(1, 32'h0, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 1, 20'h13, 20'h00055, 0, 0, 0);
    look("R5 no pinned fill", 20'h13);
    chk("R5 pointer unchanged", ctl_rdata, 32'h0);

    // R6 whole-buffer invalidate keeps pinned entries
    cyc(0, 0, 0, 0, 0, 1, 0, 0);
    look("R6 kept after inv_all", 20'h11);
    look("R6 kept after inv_all", 20'h12);

    // R10 fill and matching invalidate together
    cyc(1, 32'h0800_0001, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 1, 20'h11, 20'h00777, 0, 1, 20'h11);
    look("R10 fill wins", 20'h11);
    chk("R10 new page", {12'd0, lk_ppage}, 32'h0000_0777);

    // R8 lowest index wins
    cyc(1, 32'h0C00_0001, 1, 20'h20, 20'h00001, 0, 0, 0);
    cyc(1, 32'h0400_0001, 1, 20'h20, 20'h00002, 0, 0, 0);
    look("R8 priority", 20'h20);
    chk("R8 slot 1 page", {12'd0, lk_ppage}, 32'h0000_0002);

    // R7 single invalidate clears every match
    cyc(0, 0, 0, 0, 0, 0, 1, 20'h20);
    look("R7 cleared", 20'h20);
    chk("R7 no hit", {31'd0, lk_hit}, 32'h0);

    // R9 write and fill together
    cyc(1, 32'h1800_0001, 1, 20'h30, 20'h00303, 0, 0, 0);
    chk("R9 pointer from written value", ctl_rdata, 32'h1C00_0001);
    look("R9 fill used written steer", 20'h30);

    // Random mix
    for (int n = 0; n < 3000; n++) begin
      logic wr, fv, ia, io;
      logic [31:0] wd;
      wr = ($urandom % 8) == 0;
      wd = $urandom;
      fv = ($urandom % 2) == 0;
      ia = ($urandom % 16) == 0;
      io = ($urandom % 8) == 0;
      cyc(wr, wd, fv, 20'($urandom % 16), 20'($urandom), ia, io, 20'($urandom % 16));
      look("R8 random lookup", 20'($urandom % 16));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule